// File: doc/BRIEF.md
# Expansion Bus I/O Slave with Bounded Wait States

This block is an I/O-mapped slave for a legacy PC-style expansion bus. It owns a small bank of 16-bit registers placed at a fixed, even-aligned I/O window. A bus master selects a register by placing an address on the bus while the DMA indicator is low. It then pulls the read strobe or the write strobe low. On a read the block enables its data output and presents the selected register. On a write it captures the bus data and commits it when the strobe is released. The 16-bit cycle indication is a pure address decode and does not depend on the strobes.

Each register has its own wait-state count, set by a parameter table. While a strobe is active on a register that needs time, the block holds the ready line low for that many bus clocks. A hard cap of 37 clocks limits the stretch, which is about 2.5 µs at a 67 ns bus clock. When the cap ends the stretch, a timeout flag is raised. Electrical behaviour is modelled as enables: `rdata_oe_o` stands for the tri-state data driver, and `ready_low_o` stands for the open-collector pull on the ready line.

Top module: `xbus_io_slave`

## Requirements
- R1: An access hits only when `aen_i` is 0, `addr_i[15:3]` equals `BASE_ADDR[15:3]` (default 0x0300), and `addr_i[0]` is 0. The register index is `addr_i[2:1]`. Odd or out-of-window addresses produce no chip select, no ready pull, no data enable and no write.
- R2: `cs16_n_o` is 0 exactly when the address decode of R1 hits, in the same cycle, whatever the state of the two strobes.
- R3: `ready_low_o` goes to 1 combinationally in the first cycle in which a hit and a low strobe (read or write) are both present, provided the selected register's wait count is nonzero.
- R4: For wait count W, `ready_low_o` stays 1 for exactly min(W, 37) clocks of a held strobe and then drops while the strobe is still low. A register with W = 0 never pulls ready. Defaults are W = 0, 1, 5, 50 for indices 0 to 3.
- R5: If W ≥ 37, `tmo_o` rises at the clock edge that ends the stretch and stays 1 until the strobe or the hit goes away. Otherwise `tmo_o` stays 0.
- R6: `rdata_oe_o` is 1 combinationally while `rd_n_i` is 0 on a hit, and stays 1 until the first clock edge after the strobe rises. While `rdata_oe_o` is 1, `rdata_o` carries the selected register; otherwise `rdata_o` is 0.
- R7: A write on a hit commits the `wdata_i` value sampled at the last clock edge with `wr_n_i` low. The commit happens at the first edge at which `wr_n_i` is seen high. No register changes at any other time.
- R8: While `aen_i` is 1, reads, writes and chip select are all ignored. This is checked by reading the register afterwards with `aen_i` at 0.
- R9: After reset every register reads 0, and `ready_low_o`, `tmo_o` and `rdata_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aen_i | input | 1 | DMA indicator; 1 blocks all decoding |
| addr_i | input | 16 | I/O address |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| wdata_i | input | 16 | Write data from the bus |
| rdata_o | output | 16 | Read data toward the bus |
| rdata_oe_o | output | 1 | Data driver enable |
| cs16_n_o | output | 1 | Active-low 16-bit cycle select |
| ready_low_o | output | 1 | 1 = hold the ready line low |
| tmo_o | output | 1 | Wait stretch ended by the 37-clock cap |

## Verification
The hardest condition to reach is the cap ending a stretch while the strobe is still held. This is the only path that raises `tmo_o`. It needs a strobe held for more than 37 clocks on the register whose wait count is above the cap. The stimulus holds both a read and a write on index 3 for 45 clocks. It then counts the ready-pull cycles at the ports and expects exactly 37. A reference model in the bench predicts every output on every clock, including the one-clock hold of the data enable after the strobe rises.

// File: rtl/xbus_io_pkg.sv
package xbus_io_pkg;
   // clamp a wait request to the hard stretch cap
   function automatic int unsigned cap_wait(input int unsigned w, input int unsigned cap);
      return (w >= cap) ? cap : w;
   endfunction
endpackage

// File: rtl/xbus_addr_dec.sv
module xbus_addr_dec #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300
) (
   input  logic              aen_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int unsigned TOP_LSB = IDX_W + 1;

   initial begin
      assert (ADDR_W > TOP_LSB) else $error("address too narrow for window");
   end

   always_comb begin
      hit_o = !aen_i
              && (addr_i[ADDR_W-1:TOP_LSB] == BASE_ADDR[ADDR_W-1:TOP_LSB])
              && !addr_i[0];
      idx_o = addr_i[IDX_W:1];
   end
endmodule

// File: rtl/xbus_wait_gen.sv
module xbus_wait_gen
   import xbus_io_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned WAIT_W = 8,
   parameter logic [NUM_REGS*WAIT_W-1:0] WAIT_TABLE = '0,
   parameter int unsigned TMO_CYC = 37
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             pull_o,
   output logic             tmo_o
);
   localparam int unsigned CNT_W = $clog2(TMO_CYC + 2);

   logic [CNT_W-1:0]  cnt_q;
   logic              rel_q;
   logic              tmo_q;
   logic [WAIT_W-1:0] wait_sel;
   int unsigned       lim;
   int unsigned       cnt_nx;
   logic              over_cap;

   initial begin
      assert (TMO_CYC >= 1) else $error("cap must be positive");
      assert (WAIT_W >= 1 && WAIT_W <= 31) else $error("bad wait field width");
   end

   always_comb begin
      wait_sel = WAIT_TABLE[32'(idx_i)*WAIT_W +: WAIT_W];
      over_cap = 32'(wait_sel) >= TMO_CYC;
      lim      = cap_wait(32'(wait_sel), TMO_CYC);
      cnt_nx   = 32'(cnt_q) + 1;
      pull_o   = req_i && !rel_q && (lim != 0);
      tmo_o    = tmo_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rel_q <= 1'b0;
         tmo_q <= 1'b0;
      end else if (!req_i) begin
         cnt_q <= '0;
         rel_q <= 1'b0;
         tmo_q <= 1'b0;
      end else if (!rel_q) begin
         cnt_q <= CNT_W'(cnt_nx);
         if (cnt_nx >= lim) begin
            rel_q <= 1'b1;
            tmo_q <= over_cap;
         end
      end
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_q) <= TMO_CYC);

   // R4
   release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_q && req_i) |=> !pull_o);

   // R5
   tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_o && req_i) |=> tmo_o);
endmodule

// File: rtl/xbus_regfile.sv
module xbus_regfile #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W = 2,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req_i,
   input  logic              wr_n_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [NUM_REGS-1:0][DATA_W-1:0] regs_w;
   logic                            wact_q;
   logic [IDX_W-1:0]                wi_q;
   logic [DATA_W-1:0]               wd_q;
   logic                            commit;

   assign commit    = wact_q && wr_n_i;
   assign rd_data_o = regs_w[rd_idx_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wact_q <= 1'b0;
         wi_q   <= '0;
         wd_q   <= '0;
      end else begin
         wact_q <= wr_req_i;
         if (wr_req_i) begin
            wi_q <= wr_idx_i;
            wd_q <= wdata_i;
         end
      end
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_q <= RESET_VAL;
         else if (commit && (wi_q == IDX_W'(g))) r_q <= wd_q;
      end
      assign regs_w[g] = r_q;
   end

   // R7
   commit_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (regs_w[$past(wi_q)] == $past(wd_q)));

   // R7
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(regs_w));
endmodule

// File: rtl/xbus_io_slave.sv
module xbus_io_slave
   import xbus_io_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NUM_REGS = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300,
   parameter int unsigned WAIT_W = 8,
   parameter logic [NUM_REGS*WAIT_W-1:0] WAIT_TABLE = {8'd50, 8'd5, 8'd1, 8'd0},
   parameter int unsigned TMO_CYC = 37,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   parameter bit OE_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aen_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rdata_oe_o,
   output logic              cs16_n_o,
   output logic              ready_low_o,
   output logic              tmo_o
);
   localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   logic              hit;
   logic [IDX_W-1:0]  idx;
   logic              rd_req;
   logic              wr_req;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic              oe;

   initial begin
      assert (NUM_REGS >= 2 && (2 ** IDX_W) == NUM_REGS)
         else $error("register count must be a power of two");
   end

   xbus_addr_dec #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)
   ) u_dec (
      .aen_i(aen_i), .addr_i(addr_i), .hit_o(hit), .idx_o(idx)
   );

   assign rd_req   = hit && !rd_n_i;
   assign wr_req   = hit && !wr_n_i;
   assign cs16_n_o = !hit;

   xbus_wait_gen #(
      .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .WAIT_W(WAIT_W),
      .WAIT_TABLE(WAIT_TABLE), .TMO_CYC(TMO_CYC)
   ) u_wait (
      .clk(clk), .rst_n(rst_n), .req_i(rd_req || wr_req), .idx_i(idx),
      .pull_o(ready_low_o), .tmo_o(tmo_o)
   );

   xbus_regfile #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .RESET_VAL(RESET_VAL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .wr_n_i(wr_n_i),
      .wr_idx_i(idx), .wdata_i(wdata_i), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
   );

   if (OE_HOLD) begin : g_oe_hold
      logic             hold_q;
      logic [IDX_W-1:0] hidx_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= 1'b0;
            hidx_q <= '0;
         end else begin
            hold_q <= rd_req;
            if (rd_req) hidx_q <= idx;
         end
      end
      assign oe     = rd_req || hold_q;
      assign rd_idx = rd_req ? idx : hidx_q;
   end else begin : g_oe_direct
      assign oe     = rd_req;
      assign rd_idx = idx;
   end

   assign rdata_oe_o = oe;
   assign rdata_o    = oe ? rd_data : '0;

   // R8
   dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aen_i && $past(aen_i)) |-> (!rdata_oe_o && cs16_n_o && !ready_low_o));

   // R6
   oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req && $past(!rd_req)) |-> !rdata_oe_o);

   // R2
   cs_strobe_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(addr_i) && $stable(aen_i)) |-> $stable(cs16_n_o));
endmodule

// File: tb/xbus_io_slave_tb.sv
module xbus_io_slave_tb;
   localparam logic [15:0] BASE = 16'h0300;
   localparam int CAP = 37;
   int waits [4] = '{0, 1, 5, 50};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic aen = 1'b0;
   logic [15:0] addr = 16'hFFFF;
   logic rd_n = 1'b1;
   logic wr_n = 1'b1;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic rdata_oe, cs16_n, ready_low, tmo;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   int m_reg [4];
   int m_cnt;
   bit m_rel, m_tmo, m_oeh, m_wact;
   int m_oei, m_wi, m_wd;

   // observation flags, reset by the access tasks
   int n_pull, n_oe;
   bit tmo_seen, cs_seen;
   int last_rd;

   always #10 clk = ~clk;

   xbus_io_slave u_dut (
      .clk(clk), .rst_n(rst_n), .aen_i(aen), .addr_i(addr), .rd_n_i(rd_n),
      .wr_n_i(wr_n), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
      .cs16_n_o(cs16_n), .ready_low_o(ready_low), .tmo_o(tmo)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit f_hit();
      return !aen && (addr[15:3] == BASE[15:3]) && !addr[0];
   endfunction

   function automatic int f_lim(input int i);
      return (waits[i] >= CAP) ? CAP : waits[i];
   endfunction

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         bit h, rq, wq, ep, eoe;
         int ix, ed;
         h   = f_hit();
         ix  = int'(addr[2:1]);
         rq  = h && !rd_n;
         wq  = h && !wr_n;
         ep  = (rq || wq) && !m_rel && (f_lim(ix) != 0);
         eoe = rq || m_oeh;
         ed  = eoe ? (rq ? m_reg[ix] : m_reg[m_oei]) : 0;
         chk("R2 cs16", int'(cs16_n), int'(!h));
         chk("R4 ready", int'(ready_low), int'(ep));
         chk("R5 tmo", int'(tmo), int'(m_tmo));
         chk("R6 oe", int'(rdata_oe), int'(eoe));
         chk("R6 data", int'(rdata), ed);
         if (ready_low) n_pull++;
         if (rdata_oe) begin n_oe++; last_rd = int'(rdata); end
         if (tmo) tmo_seen = 1'b1;
         if (!cs16_n) cs_seen = 1'b1;
      end
   end

   // model state update at the active edge
   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_reg[k]) m_reg[k] = 0;
         m_cnt = 0; m_rel = 0; m_tmo = 0; m_oeh = 0; m_wact = 0;
         m_oei = 0; m_wi = 0; m_wd = 0;
      end else begin
         bit h, rq, wq;
         int ix;
         h  = f_hit();
         ix = int'(addr[2:1]);
         rq = h && !rd_n;
         wq = h && !wr_n;
         if (wr_n && m_wact) m_reg[m_wi] = m_wd;
         m_wact = wq;
         if (wq) begin m_wi = ix; m_wd = int'(wdata); end
         m_oeh = rq;
         if (rq) m_oei = ix;
         if (!(rq || wq)) begin
            m_cnt = 0; m_rel = 0; m_tmo = 0;
         end else if (!m_rel) begin
            m_cnt++;
            if (m_cnt >= f_lim(ix)) begin
               m_rel = 1;
               m_tmo = (waits[ix] >= CAP);
            end
         end
      end
   end

   task automatic clear_flags();
      n_pull = 0; n_oe = 0; tmo_seen = 0; cs_seen = 0; last_rd = -1;
   endtask

   task automatic access(input bit dma, input logic [15:0] a, input bit is_wr,
                         input logic [15:0] d, input int hold);
      @(negedge clk);
      clear_flags();
      aen = dma; addr = a; wdata = d;
      if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
      repeat (hold) @(negedge clk);
      rd_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      aen = 1'b0; addr = 16'hFFFF; wdata = '0;
      @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      clear_flags();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #6;
      // R9 reset state at the ports
      chk("R9 ready", int'(ready_low), 0);
      chk("R9 tmo", int'(tmo), 0);
      chk("R9 oe", int'(rdata_oe), 0);

      // R9 registers read zero; R3 R4 R5 stretch per register
      for (int i = 0; i < 4; i++) begin
         access(1'b0, BASE + 16'(2 * i), 1'b0, '0, 45);
         chk("R9 reset value", last_rd, 0);
         chk("R4 pull count read", n_pull, f_lim(i));
         chk("R5 timeout read", int'(tmo_seen), int'(waits[i] >= CAP));
      end

      // R7 writes then readback
      for (int i = 0; i < 4; i++) begin
         access(1'b0, BASE + 16'(2 * i), 1'b1, 16'hA5C0 + 16'(i * 17), 45);
         chk("R4 pull count write", n_pull, f_lim(i));
         chk("R5 timeout write", int'(tmo_seen), int'(waits[i] >= CAP));
      end
      for (int i = 0; i < 4; i++) begin
         access(1'b0, BASE + 16'(2 * i), 1'b0, '0, 3);
         chk("R7 readback", last_rd, 16'hA5C0 + i * 17);
      end

      // R3 short strobe on a slow register: pull seen, still stretching at end
      access(1'b0, BASE + 16'd4, 1'b0, '0, 2);
      chk("R3 early pull", n_pull, 2);

      // R8 DMA cycle: write and read ignored
      access(1'b1, BASE + 16'd2, 1'b1, 16'h1234, 6);
      chk("R8 cs during dma", int'(cs_seen), 0);
      chk("R8 no pull during dma", n_pull, 0);
      access(1'b1, BASE + 16'd2, 1'b0, '0, 6);
      chk("R8 no oe during dma", n_oe, 0);
      access(1'b0, BASE + 16'd2, 1'b0, '0, 3);
      chk("R8 value kept", last_rd, 16'hA5C0 + 17);

      // R1 odd address and out-of-window address ignored
      access(1'b0, BASE + 16'd3, 1'b1, 16'hBEEF, 6);
      chk("R1 odd no cs", int'(cs_seen), 0);
      access(1'b0, BASE + 16'd8, 1'b1, 16'hBEEF, 6);
      chk("R1 miss no pull", n_pull, 0);
      access(1'b0, BASE + 16'd8, 1'b0, '0, 6);
      chk("R1 miss no oe", n_oe, 0);
      access(1'b0, BASE + 16'd2, 1'b0, '0, 3);
      chk("R1 value kept", last_rd, 16'hA5C0 + 17);

      // R2 chip select with strobes idle
      @(negedge clk);
      clear_flags();
      addr = BASE + 16'd6;
      repeat (3) @(negedge clk);
      chk("R2 cs without strobe", int'(cs_seen), 1);
      chk("R2 no oe without strobe", n_oe, 0);
      addr = 16'hFFFF;
      @(negedge clk);

      // R6 hold of the data enable for one clock after strobe rise
      access(1'b0, BASE, 1'b0, '0, 4);
      chk("R6 oe cycles", n_oe, 5);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule